// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Sensing

This block controls one bank of general-purpose pins through a small word-indexed register bus. For every pin it holds a driven value and a drive enable, and it keeps a copy of the pin's input taken on the previous clock. It also holds two bias control bits per pin, which go straight out to the pad ring. Wider pin counts are built from one instance per bank, each bank decoded at its own address window.

Each pin has its own interrupt detector, set by three control bits. The first picks level or edge sensing, the second turns on detection of both edges, and the third picks the polarity. A detection sets a sticky raw status bit. An enable register gates the raw status into a masked status, and the OR of the masked status drives one interrupt line. Software acknowledges a pin by writing a one to its bit in the acknowledge word.

Top module: `gpio_irq_bank`

## Requirements
- R1: All state resets to zero. The read/write words sit at these word indexes: 1 drive value, 2 drive enable, 3 level select, 4 both-edge select, 5 polarity, 6 interrupt enable, 13 bias direction, 14 bias enable. Each reads back the last value written to it.
- R2: `pin_out` and `pin_oe` follow words 1 and 2. Word 0 reads `pin_in` as it was sampled at the previous rising clock edge.
- R3: With level select 0 and both-edge select 0, a polarity bit of 1 sets that pin's raw status on a 0-to-1 change and a bit of 0 sets it on a 1-to-0 change. The change is judged against the previous sample. Raw status reads at word 7.
- R4: With level select 0 and both-edge select 1, either change sets raw status, whatever the polarity bit is.
- R5: With level select 1, raw status is set on every clock while the input equals the polarity bit, and the both-edge bit is ignored. An acknowledge therefore has no lasting effect while the level stays active.
- R6: Writing word 9 clears the raw status bits that are 1 in the write data and leaves the bits that are 0 alone. Word 9 reads as zero.
- R7: Word 8 reads raw status AND interrupt enable, and `irq` is high exactly when that value is non-zero.
- R8: A detection and an acknowledge of the same bit in the same cycle leave the bit set.
- R9: `pull_sel` and `pull_en` follow words 13 and 14. Enable 1 turns the resistor on, and select 1 then means pull-up while select 0 means pull-down.
- R10: Writes to words 0, 7 and 8 and to the unused indexes 10, 11, 12 and 15 change nothing, and the unused indexes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pad input values |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| pull_en | output | 32 | Bias resistor enables |
| pull_sel | output | 32 | Bias direction, 1 for up |
| irq | output | 1 | Combined interrupt |

## Verification
Two things can land on the same status bit in one clock: a detection (an edge, or an active level) and an acknowledge write. The bench arranges this by raising a rising-sense pin in the same cycle that it writes that pin's bit to word 9. It also acknowledges a level-sensed pin while its level is still active. In both cases the bit must read back as set. A cycle-level model in the bench tracks every register and compares the read data and all outputs on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_DIN   = 4'd0,
    IDX_DOUT  = 4'd1,
    IDX_OE    = 4'd2,
    IDX_LEVEL = 4'd3,
    IDX_BOTH  = 4'd4,
    IDX_POL   = 4'd5,
    IDX_EN    = 4'd6,
    IDX_RAW   = 4'd7,
    IDX_MSK   = 4'd8,
    IDX_ACK   = 4'd9,
    IDX_PSEL  = 4'd13,
    IDX_PEN   = 4'd14
  } reg_idx_e;

  localparam int unsigned NCTRL = 8;

  // Storage slot k of the control file maps to this word index
  function automatic logic [IDX_W-1:0] ctrl_idx(input int k);
    case (k)
      0:       ctrl_idx = IDX_DOUT;
      1:       ctrl_idx = IDX_OE;
      2:       ctrl_idx = IDX_LEVEL;
      3:       ctrl_idx = IDX_BOTH;
      4:       ctrl_idx = IDX_POL;
      5:       ctrl_idx = IDX_EN;
      6:       ctrl_idx = IDX_PSEL;
      default: ctrl_idx = IDX_PEN;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [NPINS-1:0]     wr_data,
  output logic [NPINS-1:0]     dout_q,
  output logic [NPINS-1:0]     oe_q,
  output logic [NPINS-1:0]     lvl_q,
  output logic [NPINS-1:0]     both_q,
  output logic [NPINS-1:0]     pol_q,
  output logic [NPINS-1:0]     en_q,
  output logic [NPINS-1:0]     psel_q,
  output logic [NPINS-1:0]     pen_q
);
  logic [NPINS-1:0] slot_q [NCTRL];
  logic             hit    [NCTRL];

  for (genvar k = 0; k < NCTRL; k++) begin : g_slot
    logic [NPINS-1:0] nxt;
    always_comb begin
      hit[k] = wr_en && (wr_idx == ctrl_idx(k));
      nxt    = hit[k] ? wr_data : slot_q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= '0;
      else        slot_q[k] <= nxt;
    end
  end

  assign dout_q = slot_q[0];
  assign oe_q   = slot_q[1];
  assign lvl_q  = slot_q[2];
  assign both_q = slot_q[3];
  assign pol_q  = slot_q[4];
  assign en_q   = slot_q[5];
  assign psel_q = slot_q[6];
  assign pen_q  = slot_q[7];

  logic wr_ctrl;
  always_comb begin
    wr_ctrl = 1'b0;
    for (int k = 0; k < NCTRL; k++) wr_ctrl = wr_ctrl | hit[k];
  end

  // R10: writes that miss every control word leave the file unchanged
  p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctrl) |=> $stable({dout_q, oe_q, lvl_q, both_q, pol_q, en_q, psel_q, pen_q}));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic             ack_en,
  input  logic [NPINS-1:0] ack_bits,
  output logic [NPINS-1:0] samp_q,
  output logic [NPINS-1:0] raw_q
);
  logic [NPINS-1:0] ev;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] raw_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_sense
    logic hit;
    always_comb begin
      if (lvl[i])       hit = ~(pin_in[i] ^ pol[i]);
      else if (both[i]) hit = pin_in[i] ^ samp_q[i];
      else if (pol[i])  hit = pin_in[i] & ~samp_q[i];
      else              hit = ~pin_in[i] & samp_q[i];
    end
    assign ev[i] = hit;
  end

  always_comb begin
    clr_mask = ack_en ? ack_bits : '0;
    raw_d    = (raw_q & ~clr_mask) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      raw_q  <= '0;
    end else begin
      samp_q <= pin_in;
      raw_q  <= raw_d;
    end
  end

  // R6: a latched bit only drops through an acknowledge
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_q & ~clr_mask)) |=> ((raw_q & $past(raw_q & ~clr_mask)) == $past(raw_q & ~clr_mask)));

  // R8: a detection is never lost, even beside an acknowledge
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));

  // R3: a bit only rises when its detector fired
  p_rise_needs_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pull_en,
  output logic [NPINS-1:0] pull_sel,
  output logic             irq
);
  logic [NPINS-1:0] lvl_q, both_q, pol_q, en_q;
  logic [NPINS-1:0] samp_q, raw_q, msk_st;
  logic             ack_en;

  gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .wr_idx  (bus_addr),
    .wr_data (bus_wdata),
    .dout_q  (pin_out),
    .oe_q    (pin_oe),
    .lvl_q   (lvl_q),
    .both_q  (both_q),
    .pol_q   (pol_q),
    .en_q    (en_q),
    .psel_q  (pull_sel),
    .pen_q   (pull_en)
  );

  assign ack_en = bus_we && (bus_addr == IDX_ACK);

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .lvl      (lvl_q),
    .both     (both_q),
    .pol      (pol_q),
    .ack_en   (ack_en),
    .ack_bits (bus_wdata),
    .samp_q   (samp_q),
    .raw_q    (raw_q)
  );

  assign msk_st = raw_q & en_q;
  assign irq    = |msk_st;

  always_comb begin
    case (bus_addr)
      IDX_DIN:   bus_rdata = samp_q;
      IDX_DOUT:  bus_rdata = pin_out;
      IDX_OE:    bus_rdata = pin_oe;
      IDX_LEVEL: bus_rdata = lvl_q;
      IDX_BOTH:  bus_rdata = both_q;
      IDX_POL:   bus_rdata = pol_q;
      IDX_EN:    bus_rdata = en_q;
      IDX_RAW:   bus_rdata = raw_q;
      IDX_MSK:   bus_rdata = msk_st;
      IDX_PSEL:  bus_rdata = pull_sel;
      IDX_PEN:   bus_rdata = pull_en;
      default:   bus_rdata = '0;
    endcase
  end

  // R7: the interrupt line needs a latched source
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|raw_q));

  // R6: the acknowledge word never returns data
  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IDX_ACK) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_drv = '0;
  logic [31:0] rdata, pin_out, pin_oe, pull_en, pull_sel;
  logic        irq;

  int nchk = 0;
  int nbad = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_drv), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_din, m_dout, m_oe, m_lvl, m_both, m_pol, m_en, m_raw, m_psel, m_pen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_din = 0; m_dout = 0; m_oe = 0; m_lvl = 0; m_both = 0;
      m_pol = 0; m_en = 0; m_raw = 0; m_psel = 0; m_pen = 0;
    end else begin
      logic [31:0] ev;
      logic [31:0] ack;
      for (int i = 0; i < 32; i++) begin
        if (m_lvl[i])       ev[i] = (pin_drv[i] == m_pol[i]);
        else if (m_both[i]) ev[i] = (pin_drv[i] != m_din[i]);
        else if (m_pol[i])  ev[i] = pin_drv[i] && !m_din[i];
        else                ev[i] = !pin_drv[i] && m_din[i];
      end
      ack = (we && addr == 4'd9) ? wdata : 32'h0;
      if (we) begin
        case (addr)
          4'd1:  m_dout = wdata;
          4'd2:  m_oe   = wdata;
          4'd3:  m_lvl  = wdata;
          4'd4:  m_both = wdata;
          4'd5:  m_pol  = wdata;
          4'd6:  m_en   = wdata;
          4'd13: m_psel = wdata;
          4'd14: m_pen  = wdata;
          default: ;
        endcase
      end
      m_raw = (m_raw & ~ack) | ev;
      m_din = pin_drv;
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0:  return m_din;
      4'd1:  return m_dout;
      4'd2:  return m_oe;
      4'd3:  return m_lvl;
      4'd4:  return m_both;
      4'd5:  return m_pol;
      4'd6:  return m_en;
      4'd7:  return m_raw;
      4'd8:  return m_raw & m_en;
      4'd13: return m_psel;
      4'd14: return m_pen;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check($sformatf("read word %0d", addr), rdata, exp_read(addr));
    check("pin_out", pin_out, m_dout);
    check("pin_oe", pin_oe, m_oe);
    check("pull_en", pull_en, m_pen);
    check("pull_sel", pull_sel, m_psel);
    check("irq", {31'b0, irq}, {31'b0, |(m_raw & m_en)});
  endtask

  task automatic cyc(input logic [3:0] a, input logic w, input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    if (rst_n) compare_all();
    addr = a; we = w; wdata = d; pin_drv = p;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, pin_drv);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(a, 1'b0, 32'h0, pin_drv);
  endtask

  task automatic pins(input logic [31:0] p, input logic [3:0] a);
    cyc(a, 1'b0, 32'h0, p);
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values on every index
    cur_tag = "R1";
    for (int a = 0; a < 16; a++) rd(4'(a));
    // R1: readback of each control word, then clear
    wr(4'd1, 32'h1111_0001); wr(4'd2, 32'h2222_0002); wr(4'd3, 32'h3333_0003);
    wr(4'd4, 32'h4444_0004); wr(4'd5, 32'h5555_0005); wr(4'd6, 32'h6666_0006);
    wr(4'd13, 32'h7777_000D); wr(4'd14, 32'h8888_000E);
    for (int a = 0; a < 16; a++) rd(4'(a));
    for (int a = 1; a < 7; a++) wr(4'(a), 32'h0);
    wr(4'd9, 32'hFFFF_FFFF);

    // R2: drive side and one-cycle input sample
    cur_tag = "R2";
    wr(4'd1, 32'hA5A5_5A5A); wr(4'd2, 32'h0F0F_F0F0);
    pins(32'h1234_5678, 4'd0); rd(4'd0); pins(32'hCAFE_0000, 4'd0); rd(4'd0);
    pins(32'h0, 4'd0); rd(4'd0);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd7);

    // R3: default polarity 0 is falling-edge; then rising on low byte
    cur_tag = "R3";
    pins(32'hFFFF_0000, 4'd7); rd(4'd7);
    pins(32'h0, 4'd7); rd(4'd7);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd5, 32'h0000_00FF);
    pins(32'h0000_00F0, 4'd7); rd(4'd7);
    pins(32'h0, 4'd7); rd(4'd7);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd7);

    // R4: both edges regardless of polarity
    cur_tag = "R4";
    wr(4'd4, 32'h0000_FF00); wr(4'd5, 32'h0000_0F00);
    pins(32'h0000_FF00, 4'd7); rd(4'd7);
    wr(4'd9, 32'h0000_FF00); rd(4'd7);
    pins(32'h0, 4'd7); rd(4'd7);
    wr(4'd9, 32'hFFFF_FFFF); wr(4'd4, 32'h0); wr(4'd5, 32'h0);
    rd(4'd7);

    // R5: level sensing re-asserts while active; both-edge ignored
    cur_tag = "R5";
    wr(4'd5, 32'h0005_0000); wr(4'd4, 32'h000F_0000); wr(4'd3, 32'h000F_0000);
    pins(32'h000A_0000, 4'd7); rd(4'd7);
    wr(4'd9, 32'h000F_0000); rd(4'd7);
    pins(32'h0005_0000, 4'd7); rd(4'd7);
    wr(4'd9, 32'h000F_0000); rd(4'd7);
    pins(32'h000A_0000, 4'd7);
    wr(4'd3, 32'h0); wr(4'd4, 32'h0); wr(4'd5, 32'h0);
    pins(32'h0, 4'd7);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd7);

    // R6: zero bits leave status alone, one bits clear, word reads zero
    cur_tag = "R6";
    pins(32'hFFFF_FFFF, 4'd7); pins(32'h0, 4'd7); rd(4'd7);
    wr(4'd9, 32'h0); rd(4'd7);
    wr(4'd9, 32'h0F0F_0F0F); rd(4'd7); rd(4'd9);

    // R7: enable gating and the combined line
    cur_tag = "R7";
    wr(4'd6, 32'h0000_00F0); rd(4'd8);
    wr(4'd6, 32'h0000_000F); rd(4'd8);
    wr(4'd6, 32'h8000_0000); rd(4'd8);
    wr(4'd9, 32'h8000_0000); rd(4'd8);
    wr(4'd6, 32'h0); wr(4'd9, 32'hFFFF_FFFF); rd(4'd8);

    // R8: detection and acknowledge on the same bit in one cycle
    cur_tag = "R8";
    wr(4'd5, 32'h0000_0001); wr(4'd6, 32'h0000_0001);
    cyc(4'd9, 1'b1, 32'h0000_0001, 32'h0000_0001);
    rd(4'd7); rd(4'd8);
    wr(4'd9, 32'h0000_0001); rd(4'd7);

    // R9: bias controls
    cur_tag = "R9";
    wr(4'd13, 32'hF0F0_3C3C); wr(4'd14, 32'hFF00_FF00);
    rd(4'd13); rd(4'd14);

    // R10: read-only and unused indexes ignore writes
    cur_tag = "R10";
    pins(32'h0000_0100, 4'd0);
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 7 || a == 8 || a == 10 || a == 11 || a == 12 || a == 15)
        wr(4'(a), 32'hFFFF_FFFE);
    end
    for (int a = 0; a < 16; a++) rd(4'(a));

    @(negedge clk);
    compare_all();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule